// File: doc/BRIEF.md
# Cache-Line Burst Bus Master

This block moves whole cache lines across a pipelined processor bus with a 64-bit data path. A client asks for either a line fill, which is a burst read, or a line writeback, which is a burst write. The block opens each bus cycle with a one-clock active-low address strobe. It then transfers four data beats, and each beat is paced by an active-low burst-ready input from the memory side. Waits between beats may last any number of clocks, and the block has no timeout.

Write data come from a 256-bit line register, which is loaded when the request is accepted. Read beats are gathered into a 256-bit fill line. A fill request can carry an eviction flag that names a modified victim. In that case the victim's writeback burst is started in the clock right after the fill's last ready, with no idle cycle between the two bursts. Standalone writebacks serve snoop hits and cache flushes.

The data bus is modelled as an output, an input and an output enable. The enable is high only while a write burst is in its data phase.

Top module: `bwb_master`

## Requirements
- R1: During and straight after reset, `ads_n` is 1, `data_oe` is 0, `busy` is 0 and both done pulses are 0.
- R2: Each accepted burst asserts `ads_n` low for exactly one clock. While `ads_n` is low, `bus_addr` holds the request address with its low 5 bits cleared, and `bus_wr` is 1 for a write and 0 for a read.
- R3: For a write burst, `data_oe` is 0 in the strobe clock. From the first clock after the strobe, `data_oe` is 1 and beat 0 is on `data_out`.
- R4: Write data move to the next beat only after a clock edge at which `brdy_n` was sampled low. Otherwise the current beat is held for as long as the memory side waits.
- R5: Every burst has exactly four beats in linear order. Beat k carries bits [64k+63:64k] of the line.
- R6: On a fill, the `data_in` value sampled at the k-th low `brdy_n` lands in bits [64k+63:64k] of `fill_line`. Values on `data_in` at edges where `brdy_n` is high are ignored.
- R7: `fill_done` (after a read burst) or `wb_done` (after a write burst) is 1 for exactly the one clock after the fourth sampled ready. The two pulses are never high together.
- R8: A fill accepted with `req_evict`=1 is followed by a write burst to `vic_addr` (low 5 bits cleared) carrying `wb_line`. That burst's strobe falls in the clock right after the fill's fourth ready. `req_evict` has no effect on a writeback request.
- R9: `data_oe` is 0 whenever no write burst is in its data phase. This covers idle clocks, strobe clocks and the whole of a read burst.
- R10: A request raised while `busy` is 1 is ignored and starts no bus cycle.
- R11: `brdy_n` driven low while idle or in a strobe clock does not count as a beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | Request strobe, taken when not busy |
| req_wr | input | 1 | 1 = line writeback, 0 = line fill |
| req_evict | input | 1 | Fill only: chain a victim writeback |
| req_addr | input | AW | Address of the requested line |
| vic_addr | input | AW | Victim line address for a chained writeback |
| wb_line | input | 256 | Line to write (standalone or victim) |
| busy | output | 1 | A request is in progress |
| fill_line | output | 256 | Assembled fill data |
| fill_done | output | 1 | One-clock pulse after a fill burst |
| wb_done | output | 1 | One-clock pulse after a write burst |
| ads_n | output | 1 | Active-low address strobe |
| bus_addr | output | AW | Line-aligned bus address |
| bus_wr | output | 1 | Direction of the current bus cycle |
| data_out | output | 64 | Write beat driven to the bus |
| data_oe | output | 1 | Output enable for `data_out` |
| data_in | input | 64 | Read beat from the bus |
| brdy_n | input | 1 | Active-low burst ready |

## Verification
A wrong beat counter shows up on the next write beat as a mismatched `data_out` word. On a fill it shows up as a misplaced slice of `fill_line` when `fill_done` rises, and a counter that misses the end appears as a missing or late done pulse. A stuck or corrupted sequencer state shows up in the strobe clock. The symptoms there are a strobe wider than one clock, `data_oe` rising during a read or a strobe clock, or an extra strobe with no request behind it. A lost chain flag shows up as a missing victim strobe in the clock right after the fill's last ready.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } bwb_state_e;
endpackage

// File: rtl/bwb_beat_ctr.sv
module bwb_beat_ctr #(
   parameter int BEATS = 4,
   localparam int BW = $clog2(BEATS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [BW-1:0] beat,
   output logic          last
);
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("bwb_beat_ctr: BEATS must be a power of two, at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    beat <= '0;
      else if (clr)  beat <= '0;
      else if (inc)  beat <= beat + 1'b1;
   end

   assign last = (beat == BW'(BEATS - 1));

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(beat)); // R4
endmodule

// File: rtl/bwb_line_path.sv
module bwb_line_path #(
   parameter int DW    = 64,
   parameter int BEATS = 4,
   localparam int LW = DW * BEATS,
   localparam int BW = $clog2(BEATS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] line_in,
   input  logic [BW-1:0] beat,
   input  logic          cap,
   input  logic [DW-1:0] bus_in,
   output logic [DW-1:0] drive_data,
   output logic [LW-1:0] fill_line
);
   logic [LW-1:0] wb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wb_q <= '0;
      else if (load) wb_q <= line_in;
   end

   assign drive_data = wb_q[beat*DW +: DW];

   for (genvar g = 0; g < BEATS; g++) begin : g_slot
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          slot_q <= '0;
         else if (cap && beat == BW'(g))      slot_q <= bus_in;
      end
      assign fill_line[g*DW +: DW] = slot_q;
   end

   AST_FILL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(fill_line)); // R6
endmodule

// File: rtl/bwb_master.sv
module bwb_master
   import bwb_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int BEATS = 4,
   localparam int LW    = DW * BEATS,
   localparam int BW    = $clog2(BEATS),
   localparam int OFF_W = $clog2(LW / 8)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_go,
   input  logic          req_wr,
   input  logic          req_evict,
   input  logic [AW-1:0] req_addr,
   input  logic [AW-1:0] vic_addr,
   input  logic [LW-1:0] wb_line,
   output logic          busy,
   output logic [LW-1:0] fill_line,
   output logic          fill_done,
   output logic          wb_done,
   output logic          ads_n,
   output logic [AW-1:0] bus_addr,
   output logic          bus_wr,
   output logic [DW-1:0] data_out,
   output logic          data_oe,
   input  logic [DW-1:0] data_in,
   input  logic          brdy_n
);
   if (DW % 8 != 0) begin : g_bad_dw
      $error("bwb_master: DW must be a whole number of bytes");
   end
   if (AW <= OFF_W) begin : g_bad_aw
      $error("bwb_master: AW too narrow for the line offset");
   end

   bwb_state_e    state_q;
   logic          chain_q;
   logic [AW-1:0] vic_q;
   logic [BW-1:0] beat;
   logic          beat_last;
   logic          accept;
   logic          in_data;
   logic          rdy_hit;
   logic          burst_end;

   assign accept    = req_go && (state_q == ST_IDLE);
   assign in_data   = (state_q == ST_DATA);
   assign rdy_hit   = in_data && !brdy_n;
   assign burst_end = rdy_hit && beat_last;

   function automatic logic [AW-1:0] line_align(input logic [AW-1:0] a);
      return {a[AW-1:OFF_W], {OFF_W{1'b0}}};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ads_n    <= 1'b1;
         bus_addr <= '0;
         bus_wr   <= 1'b0;
         chain_q  <= 1'b0;
         vic_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q  <= ST_ADDR;
               ads_n    <= 1'b0;
               bus_addr <= line_align(req_addr);
               bus_wr   <= req_wr;
               chain_q  <= !req_wr && req_evict;
               vic_q    <= line_align(vic_addr);
            end
            ST_ADDR: begin
               ads_n   <= 1'b1;
               state_q <= ST_DATA;
            end
            ST_DATA: if (burst_end) begin
               if (chain_q) begin
                  state_q  <= ST_ADDR;
                  ads_n    <= 1'b0;
                  bus_addr <= vic_q;
                  bus_wr   <= 1'b1;
                  chain_q  <= 1'b0;
               end else begin
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_done <= 1'b0;
         wb_done   <= 1'b0;
      end else begin
         fill_done <= burst_end && !bus_wr;
         wb_done   <= burst_end && bus_wr;
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign data_oe = in_data && bus_wr;

   bwb_beat_ctr #(.BEATS(BEATS)) i_beat_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_data),
      .inc   (rdy_hit),
      .beat  (beat),
      .last  (beat_last)
   );

   bwb_line_path #(.DW(DW), .BEATS(BEATS)) i_line_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .line_in    (wb_line),
      .beat       (beat),
      .cap        (rdy_hit && !bus_wr),
      .bus_in     (data_in),
      .drive_data (data_out),
      .fill_line  (fill_line)
   );

   AST_ADS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |=> ads_n); // R2
   AST_NO_DRIVE_IN_ADS: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |-> !data_oe); // R3
   AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && brdy_n) |=> $stable(data_out)); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_done || wb_done) |=> !(fill_done || wb_done)); // R7
   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_done && wb_done)); // R7
   AST_CHAIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_end && !bus_wr && chain_q) |=> (!ads_n && bus_wr)); // R8
endmodule

// File: tb/test_bwb_master.sv
module test_bwb_master;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 64;
   localparam int LW = 256;

   typedef struct packed {
      logic          wr;
      logic [AW-1:0] addr;
      logic [LW-1:0] line;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_go = 1'b0;
   logic          req_wr = 1'b0;
   logic          req_evict = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [AW-1:0] vic_addr = '0;
   logic [LW-1:0] wb_line = '0;
   logic          busy;
   logic [LW-1:0] fill_line;
   logic          fill_done, wb_done;
   logic          ads_n;
   logic [AW-1:0] bus_addr;
   logic          bus_wr;
   logic [DW-1:0] data_out;
   logic          data_oe;
   logic [DW-1:0] data_in = '0;
   logic          brdy_n = 1'b1;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    monitor_on = 1'b0;
   bit    ended = 1'b0;
   item_t exp_q[$];
   item_t cur;
   bit    in_burst = 1'b0;
   bit    done_due = 1'b0;
   bit    glitch = 1'b0;
   bit    idle_tog = 1'b0;
   int    beat = 0;
   int    gap = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bwb_master i_bwb_master (
      .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_wr(req_wr),
      .req_evict(req_evict), .req_addr(req_addr), .vic_addr(vic_addr),
      .wb_line(wb_line), .busy(busy), .fill_line(fill_line),
      .fill_done(fill_done), .wb_done(wb_done), .ads_n(ads_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .data_out(data_out),
      .data_oe(data_oe), .data_in(data_in), .brdy_n(brdy_n)
   );

   task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                      input logic [LW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] algn(input logic [AW-1:0] a);
      return {a[AW-1:5], 5'b0};
   endfunction

   function automatic logic [LW-1:0] rnd_line();
      logic [LW-1:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // driver: raises one request and records the bursts it should produce
   task automatic issue(input bit wr, input bit ev, input logic [AW-1:0] a,
                        input logic [AW-1:0] va, input logic [LW-1:0] wl,
                        input logic [LW-1:0] fl);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_go <= 1'b1; req_wr <= wr; req_evict <= ev;
      req_addr <= a; vic_addr <= va; wb_line <= wl;
      if (wr) exp_q.push_back('{1'b1, algn(a), wl});
      else begin
         exp_q.push_back('{1'b0, algn(a), fl});
         if (ev) exp_q.push_back('{1'b1, algn(va), wl});
      end
      @(negedge clk);
      req_go <= 1'b0;
   endtask

   // R10: a request while busy must start nothing
   task automatic poke_busy();
      @(negedge clk);
      if (busy) begin
         req_go <= 1'b1; req_wr <= $urandom; req_evict <= 1'b1;
         req_addr <= $urandom; vic_addr <= $urandom; wb_line <= rnd_line();
         @(negedge clk);
         req_go <= 1'b0;
      end
   endtask

   // monitor and memory model, all at the falling edge
   always @(negedge clk) begin
      if (rst_n && monitor_on) begin
         if (done_due) begin
            done_due = 1'b0;
            if (cur.wr) chk(wb_done === 1'b1 && fill_done === 1'b0, "R7 wb_done",
                            {wb_done, fill_done}, 2'b10);
            else begin
               chk(fill_done === 1'b1 && wb_done === 1'b0, "R7 fill_done",
                   {fill_done, wb_done}, 2'b10);
               chk(fill_line === cur.line, "R6 fill_line", fill_line, cur.line);
            end
         end else begin
            chk(!fill_done && !wb_done, "R7 stray done", {fill_done, wb_done}, 0);
         end
         if (ads_n === 1'b0) begin
            if (in_burst || exp_q.size() == 0) begin
               chk(1'b0, "R10 unexpected strobe", bus_addr, 0);
            end else begin
               cur = exp_q.pop_front();
               chk(bus_wr === cur.wr, "R2 R8 bus_wr", bus_wr, cur.wr);
               chk(bus_addr === cur.addr, "R2 R8 bus_addr", bus_addr, cur.addr);
               chk(data_oe === 1'b0, "R3 oe in strobe", data_oe, 0);
               in_burst = 1'b1; beat = 0; gap = $urandom % 3;
               brdy_n <= glitch;   // R11: ready in strobe clock is ignored
               glitch = !glitch;
               data_in <= {$urandom, $urandom};
            end
         end else if (in_burst) begin
            if (cur.wr)
               chk(data_oe === 1'b1 && data_out === cur.line[beat*64 +: 64],
                   "R3 R4 R5 write beat", data_out, cur.line[beat*64 +: 64]);
            else
               chk(data_oe === 1'b0, "R9 oe in read", data_oe, 0);
            if (gap > 0) begin
               gap--;
               brdy_n <= 1'b1;
               data_in <= {$urandom, $urandom};
            end else begin
               brdy_n <= 1'b0;
               data_in <= cur.line[beat*64 +: 64];
               beat++;
               gap = $urandom % 3;
               if (beat == 4) begin in_burst = 1'b0; done_due = 1'b1; end
            end
         end else begin
            chk(data_oe === 1'b0, "R9 oe idle", data_oe, 0);
            brdy_n <= idle_tog;    // R11: ready while idle is ignored
            idle_tog = !idle_tog;
            data_in <= {$urandom, $urandom};
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 0);
      finish_run();
   end

   initial begin
      logic [LW-1:0] l1, l2;
      repeat (3) @(negedge clk);
      chk(ads_n === 1'b1 && data_oe === 1'b0 && busy === 1'b0, "R1 in reset",
          {ads_n, data_oe, busy}, 3'b100);
      rst_n <= 1'b1;
      @(negedge clk);
      chk(ads_n === 1'b1 && data_oe === 1'b0 && busy === 1'b0 &&
          fill_done === 1'b0 && wb_done === 1'b0, "R1 after reset",
          {ads_n, data_oe, busy, fill_done, wb_done}, 5'b10000);
      monitor_on = 1'b1;

      // standalone writeback, unaligned address
      issue(1'b1, 1'b0, 32'h0000_1234, 32'h0, rnd_line(), '0);
      // writeback with evict flag set: flag must be ignored (R8)
      issue(1'b1, 1'b1, 32'h0000_2040, 32'h0000_9000, rnd_line(), '0);
      // plain fill
      issue(1'b0, 1'b0, 32'h0000_3017, 32'h0, rnd_line(), rnd_line());
      // fill that evicts a modified victim (R8 chain)
      issue(1'b0, 1'b1, 32'h0000_4000, 32'h0000_5fff, rnd_line(), rnd_line());
      // requests while busy (R10)
      issue(1'b0, 1'b1, 32'h0000_6008, 32'h0000_7010, rnd_line(), rnd_line());
      poke_busy();
      poke_busy();
      issue(1'b1, 1'b0, 32'h0000_8000, 32'h0, rnd_line(), '0);
      poke_busy();
      // a mixed run
      for (int i = 0; i < 24; i++) begin
         l1 = rnd_line(); l2 = rnd_line();
         issue(1'(i % 2), 1'(i % 3 == 0), $urandom, $urandom, l1, l2);
         if (i % 5 == 0) poke_busy();
      end

      @(negedge clk);
      while (busy || in_burst || done_due) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0 && !in_burst, "R2 all bursts seen", exp_q.size(), 0);
      chk(busy === 1'b0 && ads_n === 1'b1, "R10 idle at end", {busy, ads_n}, 2'b01);
      finish_run();
   end
endmodule